// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block acts as the target side of a two-wire serial bus and presents a 1024-byte memory. The memory is split into four blocks of 256 bytes. The block number travels inside the 7-bit device address, so each transaction needs only one 8-bit word address. A bus master writes one byte, or up to a page of sixteen bytes, through an internal page buffer. It reads back from any address, either with a repeated start or by continuing from the internal address counter. A read can run for any number of bytes.

The bus lines are oversampled by the system clock. The data line is open-drain: the block never drives it high, and `sda_oe` high means that it pulls the line low. A stop that ends a write copies the buffered bytes into the array. After that copy, a self-timed busy interval of a set number of clock cycles follows. During this interval the block ignores the bus completely. A master learns that the write has finished by polling the device address until it is acknowledged.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges a device-address byte whose upper seven bits are `1010`, then the strap level, then two block bits. It acknowledges in either direction; the eighth bit is 1 for read and 0 for write. Every other address gets no acknowledge, and the data line stays released during the ninth clock.
- R2: In a write, the target takes the first byte after the device address as the word address. It stores a following data byte at the 10-bit location formed by the two block bits (high) and the word address (low).
- R3: Data bytes of one write fill a 16-byte page aligned to a multiple of 16. The index inside the page wraps from 15 to 0, so a later byte replaces an earlier one at the same index. Bytes outside the page are left unchanged.
- R4: A random read returns the stored byte at the addressed location. The sequence is: write-direction address, word address, repeated start, read-direction address.
- R5: A sequential read that the master acknowledges returns consecutive locations. The counter rolls over from location 1023 to location 0.
- R6: A read-direction address that has no word-address phase before it reads from the two block bits of that address, joined with the low eight bits of the counter. The counter points one past the last byte transferred.
- R7: When the master does not acknowledge a read byte, the target releases the data line. It drives nothing more until the next start.
- R8: A stop that ends a write with at least one data byte commits the page. The target then ignores the bus for the set number of busy cycles, so its own address gets no acknowledge. After that interval it acknowledges again.
- R9: A stop that arrives before any data byte commits nothing and starts no busy interval. The location named by the word address keeps its old value.
- R10: The target changes its data-line drive only while the clock line is low.
- R11: After reset, the data line is released and every location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_a2 | input | 1 | Strap level compared with device-address bit 2 |
| sda_oe | output | 1 | Pull the data line low when high |

## Verification
The end of the busy interval and the start condition of a polling attempt can fall in the same cycle. The bench provokes this by issuing address polls back to back right after a committing stop, so that one poll always straddles the counter reaching zero. The check measures the start time of the first acknowledged poll against the stop. It must come no earlier than the busy length and no later than one poll past it, and at least one poll must be refused. A read that follows then confirms that the page was committed.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int unsigned WORD_W = 8;
    localparam int unsigned BLK_W  = 2;
    localparam int unsigned ADDR_W = WORD_W + BLK_W;
    localparam int unsigned PAGE_W = 4;
    localparam int unsigned DATA_W = 8;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADEV,
        ST_WORD,
        ST_AWORD,
        ST_WDAT,
        ST_AWDAT,
        ST_RDAT,
        ST_RACK
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [3:0]        bc;
        logic [DATA_W-1:0] sh;
        logic              oe;
        logic              rd;
        logic              mack;
        logic              wpend;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_s    = scl_pipe_q[STAGES-1];
    assign sda_s    = sda_pipe_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev_q;
    assign scl_fall = ~scl_s & scl_prev_q;
    // data edges count only while the clock line was and still is high
    assign start_ev = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_ev  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int unsigned AW = 10,
    parameter int unsigned PW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_clr,
    input  logic          buf_we,
    input  logic [PW-1:0] buf_idx,
    input  logic [DW-1:0] buf_din,
    input  logic          commit,
    input  logic [AW-PW-1:0] page,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned DEPTH    = 1 << AW;
    localparam int unsigned PAGE_LEN = 1 << PW;

    logic [DW-1:0]       mem_q  [DEPTH];
    logic [DW-1:0]       pbuf_q [PAGE_LEN];
    logic [PAGE_LEN-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (buf_clr) begin
            valid_q <= '0;
        end else if (buf_we) begin
            valid_q[buf_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) begin
            pbuf_q[buf_idx] <= buf_din;
        end
    end

    // whole page lands in one cycle; unmarked slots keep their old contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (commit) begin
            for (int j = 0; j < PAGE_LEN; j++) begin
                if (valid_q[j]) begin
                    mem_q[{page, PW'(j)}] <= pbuf_q[j];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 500000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic strap_a2,
    output logic sda_oe
);
    localparam int unsigned    CNT_W    = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

    logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
    ctl_t q, d;
    logic [CNT_W-1:0] busy_q, busy_d;
    logic commit, buf_clr, buf_we, load_rd, addr_hit;
    logic [DATA_W-1:0] rd_data;

    eeprom_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (ev_start),
        .stop_ev  (ev_stop)
    );

    eeprom_store #(.AW(ADDR_W), .PW(PAGE_W), .DW(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .buf_clr (buf_clr),
        .buf_we  (buf_we),
        .buf_idx (q.addr[PAGE_W-1:0]),
        .buf_din (q.sh),
        .commit  (commit),
        .page    (q.addr[ADDR_W-1:PAGE_W]),
        .rd_addr (q.addr),
        .rd_data (rd_data)
    );

    assign addr_hit = (q.sh[7:4] == DEV_TYPE) && (q.sh[3] == strap_a2);

    always_comb begin
        d       = q;
        busy_d  = busy_q;
        commit  = 1'b0;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        load_rd = 1'b0;
        if (busy_q != '0) begin
            busy_d  = busy_q - 1'b1;
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.wpend = 1'b0;
        end else if (ev_stop) begin
            commit  = q.wpend;
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.wpend = 1'b0;
        end else if (ev_start) begin
            d.st    = ST_DEV;
            d.bc    = '0;
            d.oe    = 1'b0;
            d.wpend = 1'b0;
        end else begin
            case (q.st)
                ST_DEV, ST_WORD, ST_WDAT: begin
                    if (scl_rise) begin
                        d.sh = {q.sh[DATA_W-2:0], sda_s};
                        d.bc = q.bc + 4'd1;
                    end else if (scl_fall && q.bc == 4'd8) begin
                        d.bc = '0;
                        case (q.st)
                            ST_DEV: begin
                                if (addr_hit) begin
                                    d.oe = 1'b1;
                                    d.rd = q.sh[0];
                                    d.addr[ADDR_W-1:WORD_W] = q.sh[2:1];
                                    d.st = ST_ADEV;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            ST_WORD: begin
                                d.addr[WORD_W-1:0] = q.sh;
                                buf_clr = 1'b1;
                                d.oe    = 1'b1;
                                d.st    = ST_AWORD;
                            end
                            default: begin
                                buf_we  = 1'b1;
                                d.addr[PAGE_W-1:0] = q.addr[PAGE_W-1:0] + 1'b1;
                                d.wpend = 1'b1;
                                d.oe    = 1'b1;
                                d.st    = ST_AWDAT;
                            end
                        endcase
                    end
                end
                ST_ADEV: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        if (q.rd) begin
                            load_rd = 1'b1;
                        end else begin
                            d.st = ST_WORD;
                            d.bc = '0;
                        end
                    end
                end
                ST_AWORD, ST_AWDAT: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_WDAT;
                        d.bc = '0;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        d.bc = q.bc + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bc == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = ST_RACK;
                        end else begin
                            d.sh = {q.sh[DATA_W-2:0], 1'b0};
                            d.oe = ~q.sh[DATA_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            load_rd = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
            if (load_rd) begin
                d.sh   = rd_data;
                d.oe   = ~rd_data[DATA_W-1];
                d.addr = q.addr + 1'b1;
                d.st   = ST_RDAT;
                d.bc   = '0;
            end
        end
        if (commit) begin
            busy_d = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '{st: ST_IDLE, bc: '0, sh: '0, oe: 1'b0, rd: 1'b0,
                        mack: 1'b0, wpend: 1'b0, addr: '0};
            busy_q <= '0;
        end else begin
            q      <= d;
            busy_q <= busy_d;
        end
    end

    assign sda_oe = q.oe;

endmodule

// File: rtl/eeprom_target_checker.sv
module eeprom_target_checker #(
    parameter int unsigned BUSY_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic commit,
    input logic stop_ev,
    input logic [$clog2(BUSY_CYCLES + 1)-1:0] busy_cnt
);
    localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

    p_oe_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    p_busy_never_acks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |-> !sda_oe);

    p_commit_loads_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (busy_cnt == CW'(BUSY_CYCLES)));

    p_busy_counts_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - 1'b1));

    p_commit_on_idle_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (stop_ev && busy_cnt == '0));

endmodule

bind i2c_eeprom_target eeprom_target_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .commit   (commit),
    .stop_ev  (ev_stop),
    .busy_cnt (busy_q)
);

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int BUSY       = 200;
    localparam int WDOG       = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic a2 = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   n_checks = 0;
    int   n_err = 0;
    int   cyc = 0;
    int   oe_viol = 0;
    logic oe_prev = 1'b0;
    bit   done = 1'b0;
    logic [7:0] exp_mem [1024];
    logic [7:0] wdat [32];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) u_i2c_eeprom_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_a2 (a2),
        .sda_oe   (sda_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && sda_oe != oe_prev && scl_m) oe_viol <= oe_viol + 1;
        oe_prev <= sda_oe;
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic bit_io(input logic b, output logic r);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        r = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(v[i], r);
        bit_io(1'b1, r);
        ack = ~r;
    endtask

    task automatic read_byte(input logic ack_m, output logic [7:0] v);
        logic r;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, r);
            v = {v[6:0], r};
        end
        bit_io(~ack_m, r);
    endtask

    function automatic logic [7:0] dev(input logic [1:0] blk, input logic rd);
        return {4'b1010, a2, blk, rd};
    endfunction

    task automatic wr_page(input logic [1:0] blk, input logic [7:0] word, input int n);
        logic ack;
        logic [9:0] idx;
        bus_start();
        write_byte(dev(blk, 1'b0), ack);
        write_byte(word, ack);
        for (int i = 0; i < n; i++) begin
            write_byte(wdat[i], ack);
            idx = {blk, word[7:4], 4'(int'(word[3:0]) + i)};
            exp_mem[idx] = wdat[i];
        end
        bus_stop();
    endtask

    task automatic rd_random(input logic [1:0] blk, input logic [7:0] word,
                             input int n, input string req);
        logic ack;
        logic [7:0] v;
        logic [9:0] idx;
        bus_start();
        write_byte(dev(blk, 1'b0), ack);
        write_byte(word, ack);
        bus_start();
        write_byte(dev(blk, 1'b1), ack);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, v);
            idx = 10'(int'({blk, word}) + i);
            check(req, int'(v), int'(exp_mem[idx]));
        end
        bus_stop();
    endtask

    task automatic rd_current(input logic [1:0] blk, input logic [9:0] base,
                              input int n, input string req);
        logic ack;
        logic [7:0] v;
        bus_start();
        write_byte(dev(blk, 1'b1), ack);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, v);
            check(req, int'(v), int'(exp_mem[10'(int'(base) + i)]));
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic r;
        logic [7:0] v;
        int acc, nacks, t0, ts;
        bit exp_ack;
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'hFF;

        tick(5);
        rst_n = 1'b1;
        tick(5);
        check("R11 data line released after reset", int'(sda_oe), 0);

        // R1: full sweep of 7-bit addresses, write direction, strap low
        for (int a = 0; a < 128; a++) begin
            bus_start();
            write_byte({7'(a), 1'b0}, ack);
            bus_stop();
            exp_ack = (a[6:3] == 4'b1010) && (a[2] == a2);
            check($sformatf("R1 address %02h ack", a), int'(ack), int'(exp_ack));
        end
        // R1: read direction on the four blocks
        for (int b = 0; b < 4; b++) begin
            bus_start();
            write_byte(dev(2'(b), 1'b1), ack);
            check("R1 read-direction ack", int'(ack), 1);
            read_byte(1'b0, v);
            bus_stop();
        end
        // R1: strap high moves the matching window
        a2 = 1'b1;
        for (int a = 8'h50; a < 8'h58; a++) begin
            bus_start();
            write_byte({7'(a), 1'b0}, ack);
            bus_stop();
            check("R1 strap-high ack", int'(ack), int'(a[2]));
        end
        a2 = 1'b0;

        rd_random(2'd2, 8'h10, 4, "R11 erased contents");

        // R2: one byte per block
        for (int b = 0; b < 4; b++) begin
            wdat[0] = 8'(17 * (b + 1) + 3);
            wr_page(2'(b), 8'(b * 44 + 3), 1);
            tick(BUSY + 50);
        end
        for (int b = 0; b < 4; b++) rd_random(2'(b), 8'(b * 44 + 3), 1, "R2 byte write");

        // R3: partial page, then a page write that wraps
        for (int i = 0; i < 9; i++) wdat[i] = 8'(i * 37 + 1);
        wr_page(2'd1, 8'h35, 9);
        tick(BUSY + 50);
        for (int i = 0; i < 20; i++) wdat[i] = 8'(i * 13 + 8'h40);
        wr_page(2'd2, 8'h3A, 20);
        tick(BUSY + 50);
        rd_random(2'd2, 8'h2F, 18, "R3 wrapped page");
        rd_random(2'd1, 8'h34, 12, "R4 multi-byte random read");

        // R5: rollover from the top of the space to location 0
        wdat[0] = 8'hC3;
        wdat[1] = 8'h3C;
        wr_page(2'd3, 8'hFE, 2);
        tick(BUSY + 50);
        rd_random(2'd3, 8'hFE, 4, "R5 sequential rollover");

        // R6: counter now at 0x002
        rd_current(2'd0, 10'h002, 2, "R6 current-address read");
        rd_current(2'd0, 10'h004, 1, "R6 current-address follow-on");

        // R7: after a master NACK the line stays released
        bus_start();
        write_byte(dev(2'd1, 1'b1), ack);
        read_byte(1'b0, v);
        acc = 0;
        for (int i = 0; i < 9; i++) begin
            bit_io(1'b1, r);
            acc = (acc << 1) | int'(r);
        end
        check("R7 released after NACK", acc, 9'h1FF);
        bus_stop();
        rd_random(2'd1, 8'h35, 1, "R7 next transfer works");

        // R8: busy polling
        for (int i = 0; i < 5; i++) wdat[i] = 8'(i * 29 + 8'h0B);
        wr_page(2'd0, 8'h90, 5);
        t0 = cyc;
        nacks = 0;
        ts = 0;
        for (int k = 0; k < 60; k++) begin
            ts = cyc;
            bus_start();
            write_byte(dev(2'd0, 1'b0), ack);
            bus_stop();
            if (ack) break;
            nacks++;
        end
        check("R8 poll refused while busy", int'(nacks > 0), 1);
        check("R8 ack not before busy end", int'(ts - t0 + 2 * Q >= BUSY - Q), 1);
        check("R8 ack soon after busy end", int'(ts - t0 <= BUSY + 52 * Q), 1);
        rd_random(2'd0, 8'h90, 5, "R8 committed page");

        // R9: stop straight after the word address
        bus_start();
        write_byte(dev(2'd0, 1'b0), ack);
        write_byte(8'h77, ack);
        bus_stop();
        bus_start();
        write_byte(dev(2'd0, 1'b0), ack);
        bus_stop();
        check("R9 no busy after dataless write", int'(ack), 1);
        rd_random(2'd0, 8'h77, 1, "R9 location unchanged");

        check("R10 drive changes with clock high", oe_viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule